// File: doc/BRIEF.md
# Banked-Stack-Pointer Register File

This block is the architectural register store of a 32-bit processor core. It holds sixteen visible general registers, split into a data class and an address class of eight each. It also holds a 32-bit program counter and a 16-bit status register. Every register is reached through a 4-bit specifier: a class bit plus a 3-bit index. Two combinational read ports and one clocked write port serve the execution pipeline.

Writes to data registers honour the operand size chosen by the decoder. A byte or word write replaces only the low part of the register. Writes to address registers always fill all 32 bits, and narrower operands are sign-extended first.

The top address register is backed by two physical stack pointers. The privilege bit of the status register chooses which of the two answers to that specifier, so only one of them can be reached at any time.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous active-high reset clears every data register, every address register, both stack pointers and the program counter, and loads the status register with 16'h2000 (supervisor).
- R2: Specifier bit 3 selects the class (0 = data, 1 = address) and bits 2:0 select the index. The two read ports return the addressed register combinationally and independently of each other.
- R3: Size code 2'b00 is byte. A byte write to a data register replaces bits 7:0 and leaves bits 31:8 unchanged.
- R4: Size code 2'b01 is word. A word write to a data register replaces bits 15:0 and leaves bits 31:16 unchanged. Size codes 2'b10 and 2'b11 both write all 32 bits.
- R5: A write to an address register replaces all 32 bits. A word operand is sign-extended from bit 15, and a byte operand is sign-extended from bit 7.
- R6: Address index 7 reads and writes the supervisor stack pointer when status bit 13 is 1, and the user stack pointer when it is 0. The stack pointer that is not selected keeps its value.
- R7: A status-register write that changes bit 13 changes the stack pointer seen at address index 7 from the cycle after the write. Output `supervisor` equals status bit 13.
- R8: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the clock edge.
- R9: The program counter and the status register each load their whole input on a clock edge while their write enable is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_spec | input | 4 | Read port A specifier {class, index} |
| rd_a_data | output | 32 | Read port A data |
| rd_b_spec | input | 4 | Read port B specifier {class, index} |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_spec | input | 4 | Write specifier {class, index} |
| wr_size | input | 2 | Operand size: 00 byte, 01 word, 10/11 long |
| wr_data | input | 32 | Write data, low-aligned |
| pc_we | input | 1 | Program counter load enable |
| pc_in | input | 32 | Program counter next value |
| pc_out | output | 32 | Program counter |
| sr_we | input | 1 | Status register load enable |
| sr_in | input | 16 | Status register next value |
| sr_out | output | 16 | Status register |
| supervisor | output | 1 | Current privilege mode (status bit 13) |

## Verification
Read data is combinational, so within the write cycle it must still show the old contents. Every write, including the status-register write that flips the mode, shows its effect exactly one clock edge later. The bench drives each stimulus on a falling edge and samples the outputs shortly after the next falling edge, which is one rising edge later. It also samples a few points inside the write cycle to confirm the old value is still seen. Reset results are sampled after the falling edge that follows the release of reset.

// File: rtl/brf_pkg.sv
package brf_pkg;

    localparam int XLEN      = 32;
    localparam int SR_W      = 16;
    localparam int NREG      = 8;
    localparam int IDXW      = $clog2(NREG);
    localparam int SPEC_W    = IDXW + 1;
    localparam int MODE_BIT  = 13;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam logic [SR_W-1:0] SR_RESET = 16'h2000;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } op_size_e;

    typedef struct packed {
        logic            is_addr;
        logic [IDXW-1:0] idx;
    } reg_spec_t;

    typedef struct packed {
        logic            en;
        reg_spec_t       spec;
        op_size_e        size;
        logic [XLEN-1:0] data;
    } wr_req_t;

    // Data-class merge: narrow writes keep the upper part of the old value.
    function automatic logic [XLEN-1:0] merge_sized(input logic [XLEN-1:0] old_v,
                                                    input logic [XLEN-1:0] new_v,
                                                    input op_size_e sz);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = {old_v[XLEN-1:BYTE_W], new_v[BYTE_W-1:0]};
            SZ_WORD: r = {old_v[XLEN-1:WORD_W], new_v[WORD_W-1:0]};
            default: r = new_v;
        endcase
        return r;
    endfunction

    // Address-class widening: narrow operands are sign-extended.
    function automatic logic [XLEN-1:0] widen_addr(input logic [XLEN-1:0] new_v,
                                                   input op_size_e sz);
        logic [XLEN-1:0] r;
        case (sz)
            SZ_BYTE: r = {{(XLEN-BYTE_W){new_v[BYTE_W-1]}}, new_v[BYTE_W-1:0]};
            SZ_WORD: r = {{(XLEN-WORD_W){new_v[WORD_W-1]}}, new_v[WORD_W-1:0]};
            default: r = new_v;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/brf_ctl_regs.sv
module brf_ctl_regs
    import brf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            pc_we,
    input  logic [XLEN-1:0] pc_in,
    input  logic            sr_we,
    input  logic [SR_W-1:0] sr_in,
    output logic [XLEN-1:0] pc_q,
    output logic [SR_W-1:0] sr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sr_q <= SR_RESET;
        end else begin
            if (pc_we) pc_q <= pc_in;
            if (sr_we) sr_q <= sr_in;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && sr_q == SR_RESET));

    assert_pc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !pc_we |=> $stable(pc_q));

    assert_sr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !sr_we |=> $stable(sr_q));

endmodule

// File: rtl/brf_data_bank.sv
module brf_data_bank
    import brf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  wr_req_t         wr,
    input  logic [IDXW-1:0] rd_a_idx,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_a_val,
    output logic [XLEN-1:0] rd_b_val
);

    logic [XLEN-1:0] q   [NREG];
    logic [XLEN-1:0] nxt [NREG];
    logic [NREG-1:0] hit;

    for (genvar i = 0; i < NREG; i++) begin : g_dreg
        assign hit[i] = wr.en && !wr.spec.is_addr && (wr.spec.idx == IDXW'(i));
        assign nxt[i] = merge_sized(q[i], wr.data, wr.size);
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst)         q[k] <= '0;
            else if (hit[k]) q[k] <= nxt[k];
        end
    end

    assign rd_a_val = q[rd_a_idx];
    assign rd_b_val = q[rd_b_idx];

    assert_byte_keeps_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !wr.spec.is_addr && wr.size == SZ_BYTE)
        |=> (q[$past(wr.spec.idx)][XLEN-1:BYTE_W] == $past(q[wr.spec.idx][XLEN-1:BYTE_W])));

    assert_word_keeps_upper_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !wr.spec.is_addr && wr.size == SZ_WORD)
        |=> (q[$past(wr.spec.idx)][XLEN-1:WORD_W] == $past(q[wr.spec.idx][XLEN-1:WORD_W])));

    assert_one_data_write_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

endmodule

// File: rtl/brf_addr_bank.sv
module brf_addr_bank
    import brf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            supervisor,
    input  wr_req_t         wr,
    input  logic [IDXW-1:0] rd_a_idx,
    input  logic [IDXW-1:0] rd_b_idx,
    output logic [XLEN-1:0] rd_a_val,
    output logic [XLEN-1:0] rd_b_val
);

    localparam int LAST = NREG - 1;
    localparam logic [IDXW-1:0] SP_IDX = IDXW'(LAST);

    // Entry LAST of the array is the user stack pointer; ssp_q is its bank twin.
    logic [XLEN-1:0] q [NREG];
    logic [XLEN-1:0] ssp_q;
    logic [XLEN-1:0] wide;
    logic [NREG-1:0] hit;
    logic            ssp_hit;

    assign wide = widen_addr(wr.data, wr.size);

    for (genvar i = 0; i < NREG; i++) begin : g_areg
        if (i == LAST) begin : g_usp
            assign hit[i] = wr.en && wr.spec.is_addr && (wr.spec.idx == SP_IDX) && !supervisor;
        end else begin : g_plain
            assign hit[i] = wr.en && wr.spec.is_addr && (wr.spec.idx == IDXW'(i));
        end
    end

    assign ssp_hit = wr.en && wr.spec.is_addr && (wr.spec.idx == SP_IDX) && supervisor;

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst)         q[k] <= '0;
            else if (hit[k]) q[k] <= wide;
        end
        if (rst)          ssp_q <= '0;
        else if (ssp_hit) ssp_q <= wide;
    end

    function automatic logic [XLEN-1:0] pick(input logic [IDXW-1:0] idx);
        return (idx == SP_IDX && supervisor) ? ssp_q : q[idx];
    endfunction

    assign rd_a_val = pick(rd_a_idx);
    assign rd_b_val = pick(rd_b_idx);

    assert_usp_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.spec.is_addr && wr.spec.idx == SP_IDX && supervisor)
        |=> $stable(q[LAST]));

    assert_ssp_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.spec.is_addr && wr.spec.idx == SP_IDX && !supervisor)
        |=> $stable(ssp_q));

    assert_word_sext_R5: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.spec.is_addr && wr.spec.idx != SP_IDX && wr.size == SZ_WORD)
        |=> (q[$past(wr.spec.idx)][XLEN-1:WORD_W] == {(XLEN-WORD_W){q[$past(wr.spec.idx)][WORD_W-1]}}));

    assert_one_bank_write_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit, ssp_hit}));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SPEC_W-1:0] rd_a_spec,
    output logic [XLEN-1:0]   rd_a_data,
    input  logic [SPEC_W-1:0] rd_b_spec,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [SPEC_W-1:0] wr_spec,
    input  logic [1:0]        wr_size,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              pc_we,
    input  logic [XLEN-1:0]   pc_in,
    output logic [XLEN-1:0]   pc_out,
    input  logic              sr_we,
    input  logic [SR_W-1:0]   sr_in,
    output logic [SR_W-1:0]   sr_out,
    output logic              supervisor
);

    reg_spec_t       sa, sb;
    wr_req_t         req;
    logic [XLEN-1:0] d_a, d_b, a_a, a_b;
    logic [SR_W-1:0] sr_q;

    assign sa  = reg_spec_t'(rd_a_spec);
    assign sb  = reg_spec_t'(rd_b_spec);
    assign req = '{en: wr_en, spec: reg_spec_t'(wr_spec),
                   size: op_size_e'(wr_size), data: wr_data};

    brf_ctl_regs u_ctl (
        .clk   (clk),
        .rst   (rst),
        .pc_we (pc_we),
        .pc_in (pc_in),
        .sr_we (sr_we),
        .sr_in (sr_in),
        .pc_q  (pc_out),
        .sr_q  (sr_q)
    );

    assign sr_out     = sr_q;
    assign supervisor = sr_q[MODE_BIT];

    brf_data_bank u_dbank (
        .clk      (clk),
        .rst      (rst),
        .wr       (req),
        .rd_a_idx (sa.idx),
        .rd_b_idx (sb.idx),
        .rd_a_val (d_a),
        .rd_b_val (d_b)
    );

    brf_addr_bank u_abank (
        .clk        (clk),
        .rst        (rst),
        .supervisor (sr_q[MODE_BIT]),
        .wr         (req),
        .rd_a_idx   (sa.idx),
        .rd_b_idx   (sb.idx),
        .rd_a_val   (a_a),
        .rd_b_val   (a_b)
    );

    assign rd_a_data = sa.is_addr ? a_a : d_a;
    assign rd_b_data = sb.is_addr ? a_b : d_b;

    assert_mode_follows_sr_R7: assert property (@(posedge clk) disable iff (rst)
        (sr_we && !rst) |=> (supervisor == $past(sr_in[MODE_BIT])));

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    // {spec[3:0], size[1:0], data[31:0], expected read-back[31:0]}
    localparam logic [69:0] VEC [NVEC] = '{
        {4'h0, 2'b10, 32'h12345678, 32'h12345678},
        {4'h0, 2'b00, 32'hAABBCCEE, 32'h123456EE},
        {4'h0, 2'b01, 32'h9999BEEF, 32'h1234BEEF},
        {4'h1, 2'b01, 32'h00008001, 32'h00008001},
        {4'hA, 2'b01, 32'h00008001, 32'hFFFF8001},
        {4'hB, 2'b01, 32'hABCD7FFF, 32'h00007FFF},
        {4'hC, 2'b10, 32'hCAFEF00D, 32'hCAFEF00D},
        {4'hD, 2'b00, 32'h12345680, 32'hFFFFFF80},
        {4'hF, 2'b10, 32'h00001000, 32'h00001000},
        {4'h7, 2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF},
        {4'h7, 2'b00, 32'h00000000, 32'hFFFFFF00},
        {4'h7, 2'b01, 32'h5555AAAA, 32'hFFFFAAAA},
        {4'h3, 2'b11, 32'h87654321, 32'h87654321}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_a_spec = '0, rd_b_spec = '0, wr_spec = '0;
    logic [31:0] rd_a_data, rd_b_data, wr_data = '0, pc_in = '0, pc_out;
    logic [1:0]  wr_size = '0;
    logic        wr_en = 1'b0, pc_we = 1'b0, sr_we = 1'b0, supervisor;
    logic [15:0] sr_in = '0, sr_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst(rst),
        .rd_a_spec(rd_a_spec), .rd_a_data(rd_a_data),
        .rd_b_spec(rd_b_spec), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_spec(wr_spec), .wr_size(wr_size), .wr_data(wr_data),
        .pc_we(pc_we), .pc_in(pc_in), .pc_out(pc_out),
        .sr_we(sr_we), .sr_in(sr_in), .sr_out(sr_out),
        .supervisor(supervisor)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] spec, input logic [1:0] sz, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_spec = spec; wr_size = sz; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_sr(input logic [15:0] v);
        @(negedge clk);
        sr_we = 1'b1; sr_in = v;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    function automatic string tag_of(input logic [3:0] spec, input logic [1:0] sz);
        if (spec[3]) return (spec[2:0] == 3'd7) ? "R6" : "R5";
        if (sz == 2'b00) return "R3";
        return "R4";
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rd_a_spec = 4'h0; rd_b_spec = 4'hF;
        #1;
        check("R1", "pc after reset", pc_out, 32'h0);
        check("R1", "sr after reset", {16'h0, sr_out}, 32'h2000);
        check("R1", "supervisor after reset", {31'h0, supervisor}, 32'h1);
        check("R1", "D0 after reset", rd_a_data, 32'h0);
        check("R1", "A7 after reset", rd_b_data, 32'h0);

        // Vector table: write then read back through port A.
        for (int v = 0; v < NVEC; v++) begin
            do_write(VEC[v][69:66], VEC[v][65:64], VEC[v][63:32]);
            rd_a_spec = VEC[v][69:66];
            #1;
            check(tag_of(VEC[v][69:66], VEC[v][65:64]), $sformatf("vector %0d", v),
                  rd_a_data, VEC[v][31:0]);
        end

        // R2: class bit separates D0 from A0; ports independent.
        rd_a_spec = 4'h8; rd_b_spec = 4'h0;
        #1;
        check("R2", "A0 untouched by D0 writes", rd_a_data, 32'h0);
        check("R2", "port B reads D0", rd_b_data, 32'h1234BEEF);
        rd_a_spec = 4'hC; rd_b_spec = 4'h3;
        #1;
        check("R2", "port A reads A4", rd_a_data, 32'hCAFEF00D);
        check("R2", "port B reads D3", rd_b_data, 32'h87654321);

        // R7/R6: mode switch to user.
        @(negedge clk);
        sr_we = 1'b1; sr_in = 16'h0000; rd_a_spec = 4'hF;
        #1;
        check("R7", "A7 during sr write still supervisor", rd_a_data, 32'h00001000);
        @(negedge clk);
        sr_we = 1'b0;
        #1;
        check("R7", "supervisor after clearing bit 13", {31'h0, supervisor}, 32'h0);
        check("R6", "A7 in user mode is USP", rd_a_data, 32'h0);
        do_write(4'hF, 2'b10, 32'h00002000);
        rd_a_spec = 4'hF;
        #1;
        check("R6", "USP written in user mode", rd_a_data, 32'h00002000);
        set_sr(16'h2000);
        #1;
        check("R7", "supervisor after setting bit 13", {31'h0, supervisor}, 32'h1);
        check("R6", "SSP kept while USP written", rd_a_data, 32'h00001000);
        set_sr(16'h0000);
        #1;
        check("R6", "USP kept while in supervisor", rd_a_data, 32'h00002000);
        set_sr(16'h2000);

        // R8: read during write sees old value.
        @(negedge clk);
        wr_en = 1'b1; wr_spec = 4'h2; wr_size = 2'b10; wr_data = 32'h11111111;
        rd_b_spec = 4'h2;
        #1;
        check("R8", "D2 during its write", rd_b_data, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R8", "D2 after its write", rd_b_data, 32'h11111111);

        // R9: pc load and hold.
        @(negedge clk);
        pc_we = 1'b1; pc_in = 32'h00400000;
        #1;
        check("R9", "pc before edge", pc_out, 32'h0);
        @(negedge clk);
        pc_we = 1'b0; pc_in = 32'hDEADBEEF;
        #1;
        check("R9", "pc loaded", pc_out, 32'h00400000);
        @(negedge clk);
        #1;
        check("R9", "pc held", pc_out, 32'h00400000);
        check("R9", "sr held", {16'h0, sr_out}, 32'h2000);

        // R1: reset mid-run.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_a_spec = 4'h7; rd_b_spec = 4'hC;
        #1;
        check("R1", "pc after second reset", pc_out, 32'h0);
        check("R1", "sr after second reset", {16'h0, sr_out}, 32'h2000);
        check("R1", "D7 after second reset", rd_a_data, 32'h0);
        check("R1", "A4 after second reset", rd_b_data, 32'h0);
        rd_a_spec = 4'hF;
        #1;
        check("R1", "SSP after second reset", rd_a_data, 32'h0);
        set_sr(16'h0000);
        #1;
        check("R1", "USP after second reset", rd_a_data, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule